// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte enters through a valid/ready stream port into a one-entry holding stage. From there it moves into a frame shift register and is sent out one bit at a time. Plain configuration pins set the frame format:
- power and transmit enable;
- bit order;
- one of four parity modes;
- a 7- or 8-bit character;
- one or two stop bits.

A divisor sets the bit period in units of an external prescaled base tick. The block drives a busy flag and a one-cycle completion pulse for every character that finishes.

The stream port follows the usual rules. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is powered and the holding stage is empty. A producer that sees `in_ready` low must hold its byte and retry, because a byte offered while ready is low is dropped. When the shifter finishes a frame and the holding stage is already full, the next frame starts with no idle gap.

Top module: `frame_tx`

## Requirements
- R1: Parity code `cfg_parity`: 2'b00 sends no parity bit, 2'b01 sends a parity bit of 0, 2'b10 sends a bit that makes the count of ones in the data bits plus parity odd, and 2'b11 makes that count even.
- R2: `cfg_len8`=1 sends 8 data bits. `cfg_len8`=0 sends 7 data bits, `in_data[6:0]`, and bit 7 has no effect on the line or on parity.
- R3: `cfg_stop2`=1 ends each frame with two high stop bits. `cfg_stop2`=0 ends it with one.
- R4: Every bit on the line lasts 2·N `base_tick` pulses, where N is `cfg_div`. A value of N below 4 behaves as N = 4. Frames sent back to back therefore start exactly (frame bits)·2·N ticks apart.
- R5: `busy` is high whenever the holding stage is full or a frame is being shifted out. It is low otherwise.
- R6: `done_irq` is a single-cycle pulse, raised once for each frame whose last stop bit completes.
- R7: `cfg_lsb_first`=1 sends the data bits least significant first. `cfg_lsb_first`=0 sends the highest active data bit first.
- R8: While `cfg_power` is low, the block is forced idle from the next clock edge: line high, `busy` low, `in_ready` low, and the held byte discarded. An aborted frame raises no `done_irq`.
- R9: While `cfg_tx_en` is low, no new frame starts. A byte already accepted stays held, `busy` stays high, and the byte is sent once `cfg_tx_en` rises.
- R10: The line idles high. A frame is, in time order: a low start bit, the data bits, the parity bit if enabled, then the stop bits.
- R11: A byte offered while `in_ready` is low is ignored, and the held byte is not altered.
- R12: A byte accepted at clock edge k while the shifter is idle and enabled drives the start bit onto the line from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Prescaled base clock enable, one pulse per base period |
| cfg_power | input | 1 | Block enable; low forces idle |
| cfg_tx_en | input | 1 | Allows new frames to start |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_parity | input | 2 | Parity mode code (R1) |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_div | input | DIV_W (16) | Bit period divisor N |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | DATA_W (8) | Stream byte |
| in_ready | output | 1 | Holding stage can accept a byte |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Data held or frame in progress |
| done_irq | output | 1 | One-cycle pulse per completed frame |

## Verification
A byte accepted at edge k drives the line low from edge k+1. The bench reads the cycle counter at the first falling clock edge where the line is low and requires it to equal k+1.

Each line bit is sampled in its middle, half a bit period after the start edge is seen and then once per bit period. Bit timing is checked by requiring the start edges of back-to-back frames to be exactly (frame bits)·2·N ticks apart.

`done_irq`, `busy` and the effect of power-off are all due one edge after their cause. The bench reads them a full bit period later, or at the very next falling edge for power-off, so that no check lands on a clock edge.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  localparam int unsigned START_BITS = 1;
  localparam int unsigned PAR_BITS   = 1;
  localparam int unsigned STOP_MAX   = 2;

endpackage

// File: rtl/frame_tx_bitclk.sv
module frame_tx_bitclk #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  // divisors under the floor behave as the floor
  assign div_eff  = (div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div;
  assign limit    = {div_eff, 1'b0} - CNT_W'(1);
  assign at_limit = (cnt_q >= limit);
  assign bit_end  = run && tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready = enable && !full_q;
  assign full     = full_q;
  assign data     = data_q;

  // accept needs an empty stage, take needs a full one: never both
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!enable) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              len8,
  input  logic              lsb_first,
  input  logic [1:0]        parity,
  input  logic              stop2,
  input  logic              bit_end,
  output logic              active,
  output logic              last,
  output logic              line,
  output logic              done
);
  localparam int FRAME_W = int'(START_BITS) + DATA_W + int'(PAR_BITS) + int'(STOP_MAX);
  localparam int CW      = $clog2(FRAME_W + 1);

  par_mode_e         pmode;
  int                n_dat;
  logic [DATA_W-1:0] rev_full;
  logic [DATA_W-1:0] rev_short;
  logic [DATA_W-1:0] ord;
  logic [DATA_W-1:0] mask;
  logic              xr;
  logic              pbit;
  logic              has_par;
  logic [FRAME_W-1:0] frm;
  logic [CW-1:0]     frm_len;

  logic [FRAME_W-1:0] shift_q;
  logic [CW-1:0]      left_q;
  logic               active_q;
  logic               done_q;

  assign pmode = par_mode_e'(parity);

  always_comb begin
    n_dat = len8 ? DATA_W : DATA_W - 1;
    for (int i = 0; i < DATA_W; i++) rev_full[i] = data[DATA_W-1-i];
    for (int i = 0; i < DATA_W - 1; i++) rev_short[i] = data[DATA_W-2-i];
    rev_short[DATA_W-1] = 1'b0;
    ord  = lsb_first ? data : (len8 ? rev_full : rev_short);
    mask = {len8, {(DATA_W-1){1'b1}}};
    xr   = ^(data & mask);
    unique case (pmode)
      PAR_ODD:  pbit = ~xr;
      PAR_EVEN: pbit = xr;
      default:  pbit = 1'b0;
    endcase
    has_par = (pmode != PAR_NONE);
    // bit 0 leaves first; unused upper bits stay high as stop bits
    frm    = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_dat) frm[1+i] = ord[i];
    end
    for (int i = 0; i <= DATA_W; i++) begin
      if (has_par && (i == n_dat)) frm[1+i] = pbit;
    end
    frm_len = CW'(1 + n_dat + (has_par ? 1 : 0) + (stop2 ? 2 : 1));
  end

  assign last   = active_q && bit_end && (left_q == CW'(1));
  assign active = active_q;
  assign line   = shift_q[0];
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '1;
      left_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (!enable) begin
      shift_q  <= '1;
      left_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        shift_q  <= frm;
        left_q   <= frm_len;
        active_q <= 1'b1;
      end else if (active_q && bit_end) begin
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        left_q  <= left_q - CW'(1);
        if (left_q == CW'(1)) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              cfg_power,
  input  logic              cfg_tx_en,
  input  logic              cfg_lsb_first,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_line,
  output logic              busy,
  output logic              done_irq
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              sh_active;
  logic              sh_last;
  logic              bit_end;
  logic              load;

  // the shifter may reload on the very edge its last stop bit ends
  assign load = cfg_power && cfg_tx_en && hold_full && (!sh_active || sh_last);
  assign busy = hold_full || sh_active;

  frame_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_power),
    .in_valid (in_valid),
    .in_data  (in_data),
    .take     (load),
    .in_ready (in_ready),
    .full     (hold_full),
    .data     (hold_data)
  );

  frame_tx_bitclk #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (sh_active),
    .tick    (base_tick),
    .div     (cfg_div),
    .bit_end (bit_end)
  );

  frame_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_power),
    .load      (load),
    .data      (hold_data),
    .len8      (cfg_len8),
    .lsb_first (cfg_lsb_first),
    .parity    (cfg_parity),
    .stop2     (cfg_stop2),
    .bit_end   (bit_end),
    .active    (sh_active),
    .last      (sh_last),
    .line      (tx_line),
    .done      (done_irq)
  );
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_power,
  input logic              in_valid,
  input logic              in_ready,
  input logic              tx_line,
  input logic              busy,
  input logic              done_irq,
  input logic              hold_full,
  input logic [DATA_W-1:0] hold_data
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line); // R10

  AST_POWER_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_power) |-> (!busy && tx_line)); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R6

  AST_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(tx_line)); // R3

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && hold_full) |=> $stable(hold_data)); // R11

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !hold_full); // R11
endmodule

bind frame_tx frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_power (cfg_power),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx_line   (tx_line),
  .busy      (busy),
  .done_irq  (done_irq),
  .hold_full (hold_full),
  .hold_data (hold_data)
);

// File: tb/test_frame_tx.sv
`timescale 1ns/1ps
module test_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b1;
  logic        cfg_power = 1'b1;
  logic        cfg_tx_en = 1'b1;
  logic        cfg_lsb_first = 1'b1;
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_len8 = 1'b1;
  logic        cfg_stop2 = 1'b0;
  logic [15:0] cfg_div = 16'd4;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, tx_line, busy, done_irq;

  int cyc = 0, n_chk = 0, n_fail = 0, irq_cnt = 0, tick_div = 1;
  bit finished = 0;

  frame_tx i_frame_tx (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cfg_power(cfg_power),
    .cfg_tx_en(cfg_tx_en), .cfg_lsb_first(cfg_lsb_first), .cfg_parity(cfg_parity),
    .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2), .cfg_div(cfg_div),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_line(tx_line), .busy(busy), .done_irq(done_irq));

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_irq) irq_cnt <= irq_cnt + 1;
  end
  always @(negedge clk) base_tick <= (tick_div == 1) ? 1'b1 : ~base_tick;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_time();
    return 2 * ((cfg_div < 16'd4) ? 4 : int'(cfg_div)) * tick_div;
  endfunction

  // expected line bits, index 0 leaves first
  task automatic exp_frame(input logic [7:0] d, output logic [11:0] f, output int nb);
    int nd;
    logic [7:0] m;
    logic p;
    nd = cfg_len8 ? 8 : 7;
    m = cfg_len8 ? 8'hFF : 8'h7F;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = cfg_lsb_first ? d[i] : d[nd-1-i];
    nb = 1 + nd;
    if (cfg_parity != 2'b00) begin
      p = (cfg_parity == 2'b01) ? 1'b0 : (cfg_parity == 2'b10) ? ~^(d & m) : ^(d & m);
      f[nb] = p;
      nb++;
    end
    nb += cfg_stop2 ? 2 : 1;
  endtask

  task automatic push(input logic [7:0] b, output int acc);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic grab(input int nb, output logic [11:0] got, output int fall);
    int bt, w;
    bt = bit_time();
    w = 0;
    got = '1;
    fall = -1;
    do begin @(negedge clk); w++; end while (tx_line && w < 20000);
    if (tx_line) begin
      chk(0, "R10", "start bit seen", 1, 0);
      return;
    end
    fall = cyc;
    repeat (bt / 2) @(negedge clk);
    got[0] = tx_line;
    for (int j = 1; j < nb; j++) begin
      repeat (bt) @(negedge clk);
      got[j] = tx_line;
    end
  endtask

  task automatic watch_idle(input int n, input string req);
    bit ok = 1;
    repeat (n) begin @(negedge clk); if (!tx_line) ok = 0; end
    chk(ok, req, "line stays idle high", ok, 1);
  endtask

  task automatic set_fmt(input bit lsb, input logic [1:0] par, input bit l8, input bit s2, input int dv);
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_parity = par; cfg_len8 = l8; cfg_stop2 = s2; cfg_div = 16'(dv);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_line == 1'b1, "R10", "reset line", tx_line, 1);
    chk(busy == 1'b0, "R5", "reset busy", busy, 0);
    chk(done_irq == 1'b0, "R6", "reset irq", done_irq, 0);
    chk(in_ready == 1'b1, "R11", "reset ready", in_ready, 1);
  endtask

  // single frame: content R1 R2 R3 R7 R10, latency R12, irq R6, busy R5
  task automatic t_frame(input logic [7:0] b);
    logic [11:0] e, g;
    int nb, acc, fall, irq0;
    exp_frame(b, e, nb);
    irq0 = irq_cnt;
    push(b, acc);
    chk(busy == 1'b1, "R5", "busy during frame", busy, 1);
    grab(nb, g, fall);
    chk(g == e, "R10/R1/R2/R3/R7", "frame bits", int'(g), int'(e));
    chk(fall == acc + 1, "R12", "start edge", fall, acc + 1);
    repeat (bit_time()) @(negedge clk);
    chk(irq_cnt == irq0 + 1, "R6", "one irq per frame", irq_cnt - irq0, 1);
    chk(busy == 1'b0, "R5", "busy low after frame", busy, 0);
  endtask

  // back to back: spacing checks R4 and R3
  task automatic t_gap(input logic [7:0] a, input logic [7:0] b);
    logic [11:0] ea, eb, ga, gb;
    int nb, acc1, acc2, f1, f2;
    exp_frame(a, ea, nb);
    exp_frame(b, eb, nb);
    fork
      begin push(a, acc1); push(b, acc2); end
      begin grab(nb, ga, f1); grab(nb, gb, f2); end
    join
    chk(ga == ea && gb == eb, "R10", "back to back bits", int'(gb), int'(eb));
    chk(f2 - f1 == nb * bit_time(), "R4", "frame spacing", f2 - f1, nb * bit_time());
    repeat (bit_time()) @(negedge clk);
  endtask

  task automatic t_ignore();
    logic [11:0] ea, eb, ga, gb;
    int nb, acc, f1, f2, irq0;
    bit rdy;
    irq0 = irq_cnt;
    exp_frame(8'h5A, ea, nb);
    exp_frame(8'hC3, eb, nb);
    fork
      begin
        push(8'h5A, acc);
        push(8'hC3, acc);
        @(negedge clk);
        rdy = in_ready;
        in_valid = 1'b1; in_data = 8'h99;
        @(negedge clk);
        in_valid = 1'b0;
        chk(rdy == 1'b0, "R11", "ready low when full", rdy, 0);
        chk(busy == 1'b1, "R5", "busy with byte held", busy, 1);
      end
      begin grab(nb, ga, f1); grab(nb, gb, f2); end
    join
    chk(ga == ea, "R11", "first frame", int'(ga), int'(ea));
    chk(gb == eb, "R11", "held byte unchanged", int'(gb), int'(eb));
    repeat (bit_time()) @(negedge clk);
    watch_idle(4 * bit_time(), "R11");
    chk(irq_cnt == irq0 + 2, "R6", "two irqs", irq_cnt - irq0, 2);
  endtask

  task automatic t_txen();
    logic [11:0] e, g;
    int nb, acc, fall;
    exp_frame(8'h3C, e, nb);
    @(negedge clk); cfg_tx_en = 1'b0;
    push(8'h3C, acc);
    watch_idle(60, "R9");
    chk(busy == 1'b1, "R9", "busy while held", busy, 1);
    chk(in_ready == 1'b0, "R9", "ready while held", in_ready, 0);
    cfg_tx_en = 1'b1;
    grab(nb, g, fall);
    chk(g == e, "R9", "held byte sent", int'(g), int'(e));
    repeat (2 * bit_time()) @(negedge clk);
  endtask

  task automatic t_power();
    int acc, irq0;
    irq0 = irq_cnt;
    push(8'hE7, acc);
    repeat (3 * bit_time()) @(negedge clk);
    chk(busy == 1'b1, "R5", "busy mid frame", busy, 1);
    cfg_power = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R8", "line after power off", tx_line, 1);
    chk(busy == 1'b0, "R8", "busy after power off", busy, 0);
    chk(in_ready == 1'b0, "R8", "ready while off", in_ready, 0);
    cfg_power = 1'b1;
    watch_idle(12 * bit_time(), "R8");
    chk(irq_cnt == irq0, "R8", "no irq for aborted frame", irq_cnt - irq0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    set_fmt(1, 2'b00, 1, 0, 4); t_frame(8'hA5);
    set_fmt(1, 2'b11, 1, 0, 4); t_frame(8'h3D);
    set_fmt(0, 2'b10, 0, 1, 4); t_frame(8'hB2);
    set_fmt(1, 2'b01, 0, 0, 5); t_frame(8'hFF);
    set_fmt(0, 2'b11, 1, 1, 4); t_frame(8'h81);
    set_fmt(1, 2'b10, 1, 0, 6); t_frame(8'h00);
    set_fmt(0, 2'b10, 0, 0, 4); t_frame(8'h80);
    set_fmt(1, 2'b00, 1, 0, 5); t_gap(8'h12, 8'h34);
    set_fmt(1, 2'b00, 1, 1, 5); t_gap(8'h56, 8'h78);
    set_fmt(0, 2'b11, 0, 0, 2); t_gap(8'h9A, 8'h1B);
    tick_div = 2;
    set_fmt(1, 2'b10, 1, 1, 4); t_gap(8'hC4, 8'h2E);
    tick_div = 1;
    set_fmt(1, 2'b11, 1, 0, 4);
    t_ignore();
    t_txen();
    t_power();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule